// File: doc/BRIEF.md
# External Interrupt Request Front-End

This block sits between three asynchronous interrupt request pins and a processor core. Each pin passes through a multi-flop synchronizer. A per-line trigger stage then recognises the request either as a rising edge, which is latched until serviced, or as a level, which is never latched. A per-line mask removes a line from arbitration. A fixed-priority arbiter offers the single winning line, with its vector type, to the core over a valid/ready pair.

Two pin reuse modes are supported. In cascade mode, pin 2 no longer requests; it becomes an active-low acknowledge strobe for an external controller that is served through line 0. In slave mode, pin 1 no longer requests; it becomes a select strobe. The strobe captures an interrupt type byte from a type bus, and only does so while line 0 is already requesting. Line 0 is then offered with the captured type.

Offer rules: `irq_valid` with `irq_line`/`irq_type` is an offer. The core takes it in the cycle where `irq_valid` and `irq_ready` are both high. Before that cycle the offer may change: a higher-priority line can preempt it, and a level line that drops withdraws it. The core must not treat an offer as committed until the handshake. Back-pressure (holding `irq_ready` low) never loses a latched edge.

Top module: `irq_front`

## Requirements
- R1: A request in level mode is visible on `irq_valid` after the second rising clock edge that follows the pin's assertion. A request in edge mode is visible after the third.
- R2: In edge mode (`cfg_level` bit = 0), a rising edge on the pin sets a pending request that persists after the pin falls. The pending request is cleared only by a handshake on that line.
- R3: A line whose `cfg_mask` bit is 1 is never offered. An edge captured while the line is masked is kept, and it is offered once the mask bit returns to 0.
- R4: In level mode (`cfg_level` bit = 1), a line is offered only while its synchronized pin is high. If the pin drops before a handshake, nothing stays pending.
- R5: Priority is fixed: line 0 first, then line 1, then line 2. `irq_line` carries the index of the offered line.
- R6: The offered type is TYPE_BASE + line index (12, 13, 14 by default), except for line 0 in slave mode.
- R7: A handshake (`irq_valid && irq_ready` at a clock edge) clears only the offered line. Other pending lines stay pending.
- R8: With `cfg_cascade` = 1, pin 2 is not a request and `pin2_oe` is 1. `pin2_ack_n` is driven low for the single cycle after each line-0 handshake. Otherwise `pin2_ack_n` stays high.
- R9: With `cfg_slave` = 1, pin 1 is not a request. A synchronized rising edge on pin 1 captures `bus_type` only while line 0 is requesting; an earlier strobe is ignored. Line 0 is offered only after a capture, and it then carries the captured type. The captured type is discarded on the line-0 handshake.
- R10: While reset is active and right after it, `irq_valid` is 0, `pin2_ack_n` is 1 and `pin2_oe` follows `cfg_cascade`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin0_req | input | 1 | Asynchronous request pin, line 0 |
| pin1_req_sel | input | 1 | Asynchronous request pin, line 1; select strobe in slave mode |
| pin2_req_in | input | 1 | Asynchronous request pin, line 2 |
| pin2_ack_n | output | 1 | Active-low acknowledge strobe for pin 2 in cascade mode |
| pin2_oe | output | 1 | Drive enable for pin 2 (high in cascade mode) |
| cfg_mask | input | 3 | Per-line mask, 1 = masked |
| cfg_level | input | 3 | Per-line trigger, 1 = level, 0 = edge |
| cfg_cascade | input | 1 | Cascade mode enable |
| cfg_slave | input | 1 | Slave mode enable |
| bus_type | input | TYPE_W | Externally supplied interrupt type |
| irq_valid | output | 1 | Offer of a request to the core |
| irq_ready | input | 1 | Core accepts the offer |
| irq_line | output | 2 | Index of the offered line |
| irq_type | output | TYPE_W | Vector type of the offered line |

## Verification
The bench builds the block with its defaults: a two-flop synchronizer, an 8-bit type and a type base of 12. With these values the exact latencies of one, two and three edges, and the arithmetic types 12 to 14, can be checked directly. The three-line width lets the bench sweep all eight mask patterns in edge mode, draining each in priority order and then releasing the masked leftovers. It also sweeps all seven nonzero level patterns. Cascade and slave modes are each exercised with a short directed sequence, including a select strobe that arrives before any line-0 request.

// File: rtl/irqf_pkg.sv
`timescale 1ns/1ps
package irqf_pkg;
  localparam int N_LINES = 3;
  localparam int LINE_W  = $clog2(N_LINES);
  typedef logic [LINE_W-1:0] line_t;
endpackage

// File: rtl/irqf_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer, one chain per bit.
module irqf_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irqf_line.sv
`timescale 1ns/1ps
// Per-line trigger stage: edge latch or transparent level.
module irqf_line (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic level_mode,
  input  logic enable,
  input  logic clr,
  output logic req
);
  logic prev, pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      pend <= 1'b0;
    end else begin
      prev <= lvl;
      if (!enable || level_mode) pend <= 1'b0;
      else if (lvl && !prev)     pend <= 1'b1;  // new edge wins over clear
      else if (clr)              pend <= 1'b0;
    end
  end

  assign req = enable && (level_mode ? lvl : pend);
endmodule

// File: rtl/irqf_arb.sv
`timescale 1ns/1ps
// Fixed priority: lowest index wins.
module irqf_arb #(
  parameter int N  = 3,
  parameter int LW = 2
) (
  input  logic [N-1:0]  cand,
  output logic          valid,
  output logic [LW-1:0] line
);
  always_comb begin
    valid = |cand;
    line  = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (cand[i]) line = LW'(i);
    end
  end
endmodule

// File: rtl/irq_front.sv
`timescale 1ns/1ps
module irq_front
  import irqf_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TYPE_W      = 8,
  parameter int TYPE_BASE   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin0_req,
  input  logic              pin1_req_sel,
  input  logic              pin2_req_in,
  output logic              pin2_ack_n,
  output logic              pin2_oe,
  input  logic [2:0]        cfg_mask,
  input  logic [2:0]        cfg_level,
  input  logic              cfg_cascade,
  input  logic              cfg_slave,
  input  logic [TYPE_W-1:0] bus_type,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [1:0]        irq_line,
  output logic [TYPE_W-1:0] irq_type
);
  logic [N_LINES-1:0] pin_s, en, clr, req, cand;
  logic               fire;
  line_t              win;
  logic               sel_prev, sel_rise, ext_valid;
  logic [TYPE_W-1:0]  ext_type;

  irqf_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({pin2_req_in, pin1_req_sel, pin0_req}),
    .q(pin_s)
  );

  // Pin reuse removes lines from the request set.
  assign en   = {~cfg_cascade, ~cfg_slave, 1'b1};
  assign fire = irq_valid && irq_ready;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    assign clr[g] = fire && (win == line_t'(g));
    irqf_line u_line (
      .clk(clk), .rst_n(rst_n),
      .lvl(pin_s[g]), .level_mode(cfg_level[g]), .enable(en[g]),
      .clr(clr[g]), .req(req[g])
    );
  end

  // Slave mode: select strobe captures an external type for line 0.
  assign sel_rise = cfg_slave && pin_s[1] && !sel_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev  <= 1'b0;
      ext_valid <= 1'b0;
      ext_type  <= '0;
    end else begin
      sel_prev <= pin_s[1];
      if (!cfg_slave || clr[0] || !req[0]) begin
        ext_valid <= 1'b0;
      end else if (sel_rise && !ext_valid) begin
        ext_valid <= 1'b1;
        ext_type  <= bus_type;
      end
    end
  end

  assign cand[0] = req[0] && !cfg_mask[0] && (!cfg_slave || ext_valid);
  assign cand[1] = req[1] && !cfg_mask[1];
  assign cand[2] = req[2] && !cfg_mask[2];

  irqf_arb #(.N(N_LINES), .LW(LINE_W)) u_arb (
    .cand(cand), .valid(irq_valid), .line(win)
  );

  assign irq_line = 2'(win);
  assign irq_type = (cfg_slave && win == '0) ? ext_type
                  : TYPE_W'(TYPE_BASE) + TYPE_W'(win);

  // Cascade acknowledge strobe, one cycle after a line-0 handshake.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin2_ack_n <= 1'b1;
    else        pin2_ack_n <= !(cfg_cascade && clr[0]);
  end

  assign pin2_oe = cfg_cascade;
endmodule

// File: rtl/irq_front_chk.sv
`timescale 1ns/1ps
module irq_front_chk #(
  parameter int TYPE_W    = 8,
  parameter int TYPE_BASE = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pin2_ack_n,
  input logic [2:0]        cfg_mask,
  input logic              cfg_cascade,
  input logic              cfg_slave,
  input logic              irq_valid,
  input logic              irq_ready,
  input logic [1:0]        irq_line,
  input logic [TYPE_W-1:0] irq_type
);
  p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !cfg_mask[irq_line]);

  p_line_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_line != 2'd3);

  p_type_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !cfg_slave) |-> irq_type == TYPE_W'(TYPE_BASE) + TYPE_W'(irq_line));

  p_no_line2_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && cfg_cascade) |-> irq_line != 2'd2);

  p_ack_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pin2_ack_n |-> $past(irq_valid && irq_ready && irq_line == 2'd0 && cfg_cascade));

  p_no_line1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && cfg_slave) |-> irq_line != 2'd1);
endmodule

bind irq_front irq_front_chk #(.TYPE_W(TYPE_W), .TYPE_BASE(TYPE_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin2_ack_n(pin2_ack_n), .cfg_mask(cfg_mask),
  .cfg_cascade(cfg_cascade), .cfg_slave(cfg_slave), .irq_valid(irq_valid),
  .irq_ready(irq_ready), .irq_line(irq_line), .irq_type(irq_type)
);

// File: tb/sim_irq_front.sv
`timescale 1ns/1ps
module sim_irq_front;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pins = '0;
  logic       pin2_ack_n, pin2_oe;
  logic [2:0] cfg_mask = '0, cfg_level = '0;
  logic       cfg_cascade = 1'b0, cfg_slave = 1'b0;
  logic [7:0] bus_type = '0;
  logic       irq_valid, irq_ready = 1'b0;
  logic [1:0] irq_line;
  logic [7:0] irq_type;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  irq_front u0 (
    .clk(clk), .rst_n(rst_n), .pin0_req(pins[0]), .pin1_req_sel(pins[1]),
    .pin2_req_in(pins[2]), .pin2_ack_n(pin2_ack_n), .pin2_oe(pin2_oe),
    .cfg_mask(cfg_mask), .cfg_level(cfg_level), .cfg_cascade(cfg_cascade),
    .cfg_slave(cfg_slave), .bus_type(bus_type), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_line(irq_line), .irq_type(irq_type)
  );

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pins = '0; irq_ready = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic handshake();
    irq_ready = 1'b1;
    tick(1);
    irq_ready = 1'b0;
  endtask

  task automatic pulse(logic [2:0] b);
    pins = b;
    tick(1);
    pins = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R10 reset state
    rst_n = 1'b0;
    tick(2);
    chk("R10 valid in reset", irq_valid, 0);
    chk("R10 ack_n in reset", pin2_ack_n, 1);
    do_reset();
    chk("R10 valid after reset", irq_valid, 0);
    chk("R10 ack_n after reset", pin2_ack_n, 1);
    chk("R10 oe", pin2_oe, 0);

    // R3/R5/R6/R7 edge-mode sweep over all masks
    for (int m = 0; m < 8; m++) begin
      do_reset();
      cfg_level = 3'b000;
      cfg_mask = 3'(m);
      pulse(3'b111);
      tick(2);
      for (int j = 0; j < 3; j++) begin
        if (!m[j]) begin
          chk("R5 valid", irq_valid, 1);
          chk("R5 line", irq_line, j);
          chk("R6 type", irq_type, 12 + j);
          handshake();
        end
      end
      chk("R3 masked not offered", irq_valid, 0);
      cfg_mask = 3'b000;
      tick(1);
      for (int j = 0; j < 3; j++) begin
        if (m[j]) begin
          chk("R3 retained line", irq_line, j);
          chk("R3 retained valid", irq_valid, 1);
          handshake();
        end
      end
      chk("R7 all cleared", irq_valid, 0);
      cfg_mask = 3'b000;
    end

    // R1/R4/R5 level-mode sweep over all nonzero patterns
    for (int p = 1; p < 8; p++) begin
      int lo;
      lo = p[0] ? 0 : (p[1] ? 1 : 2);
      do_reset();
      cfg_level = 3'b111;
      pins = 3'(p);
      tick(1);
      chk("R1 level not yet", irq_valid, 0);
      tick(1);
      chk("R1 level valid", irq_valid, 1);
      chk("R5 level line", irq_line, lo);
      chk("R6 level type", irq_type, 12 + lo);
      handshake();
      chk("R4 held level re-offered", irq_line, lo);
      pins = '0;
      tick(2);
      chk("R4 released", irq_valid, 0);
    end

    // R1/R2 edge latency and persistence
    do_reset();
    cfg_level = 3'b000;
    pulse(3'b010);
    tick(1);
    chk("R1 edge not yet", irq_valid, 0);
    tick(1);
    chk("R1 edge valid", irq_valid, 1);
    chk("R2 edge line", irq_line, 1);
    tick(6);
    chk("R2 persists", irq_valid, 1);
    handshake();
    chk("R2 cleared by handshake", irq_valid, 0);
    tick(3);
    chk("R2 stays clear", irq_valid, 0);

    // R4 early deassertion in level mode
    do_reset();
    cfg_level = 3'b111;
    pins = 3'b100;
    tick(2);
    chk("R4 level offered", irq_line, 2);
    pins = '0;
    tick(2);
    chk("R4 dropped early", irq_valid, 0);
    tick(5);
    chk("R4 nothing kept", irq_valid, 0);

    // R7 handshake clears only the winner; R8 no strobe without cascade
    do_reset();
    cfg_level = 3'b000;
    pulse(3'b101);
    tick(2);
    chk("R7 first line", irq_line, 0);
    handshake();
    chk("R8 ack_n idle without cascade", pin2_ack_n, 1);
    chk("R7 other kept", irq_valid, 1);
    chk("R7 other line", irq_line, 2);
    chk("R7 other type", irq_type, 14);
    handshake();
    chk("R7 drained", irq_valid, 0);

    // R8 cascade mode
    do_reset();
    cfg_cascade = 1'b1;
    tick(1);
    chk("R8 oe", pin2_oe, 1);
    pulse(3'b100);
    tick(4);
    chk("R8 pin2 ignored", irq_valid, 0);
    chk("R8 ack_n idle", pin2_ack_n, 1);
    pulse(3'b001);
    tick(2);
    chk("R8 line0 offered", irq_line, 0);
    irq_ready = 1'b1;
    tick(1);
    irq_ready = 1'b0;
    chk("R8 ack_n low", pin2_ack_n, 0);
    tick(1);
    chk("R8 ack_n one cycle", pin2_ack_n, 1);
    chk("R8 served", irq_valid, 0);
    cfg_cascade = 1'b0;

    // R9 slave mode
    do_reset();
    cfg_slave = 1'b1;
    bus_type = 8'h5A;
    pulse(3'b010);
    tick(4);
    chk("R9 select alone", irq_valid, 0);
    pulse(3'b001);
    tick(4);
    chk("R9 early select rejected", irq_valid, 0);
    bus_type = 8'h77;
    pulse(3'b010);
    tick(2);
    chk("R9 captured valid", irq_valid, 1);
    chk("R9 captured line", irq_line, 0);
    chk("R9 captured type", irq_type, 8'h77);
    handshake();
    chk("R9 discarded after handshake", irq_valid, 0);
    cfg_slave = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule